// File: doc/BRIEF.md
# Triggered Transient Recorder with Pre-Trigger Window

This block records a window of sample data around a trigger into an on-chip circular buffer. Once software arms it, every accepted sample is written into the buffer, which wraps without pause. A trigger fixes the split between history and aftermath. After the trigger, a programmed number of further samples is stored. The buffer then freezes and a done flag rises. Software then walks the frozen contents from the oldest entry to the newest through a simple step-and-read port.

Four trigger sources can start a capture, each behind its own enable bit:
- an external trigger pin;
- a software pulse;
- an event from the timing system;
- an internal detector that fires when the sum channel first drops below a signed threshold.

In single-shot mode, the timing event does not fire the capture directly. It starts a countdown of N turn strobes, and the capture fires when the countdown ends. An inhibit input can mark samples taken without beam so that they are never stored.

Top module: `transient_recorder`

## Requirements
- R1: After reset the recorder is idle: `armed`, `capturing` and `done` are all low.
- R2: While armed or capturing, each sample with `smp_valid` high and `inhibit` low is written at the next buffer position. A sample with `inhibit` high is not stored and does not advance the buffer.
- R3: `cfg_src_en` selects the trigger sources. Bit 0 is the rising edge of `ext_trig`, bit 1 is a `sw_trig` pulse, bit 2 is an `evt_trig` pulse, and bit 3 is the below-threshold detector. A source whose bit is clear has no effect.
- R4: The threshold detector compares `sum_data < cfg_thresh` as signed values on valid samples. It fires only on a valid sample that is below the threshold when the previous valid sample was not below it.
- R5: With `cfg_single` high, an enabled event starts a countdown of `cfg_turns` `turn_strobe` pulses and the trigger fires on the last of them. A turn strobe in the same cycle as the event is not counted. With `cfg_turns` = 0 the event fires at once.
- R6: The sample accepted in the trigger cycle belongs to the pre-trigger part. After it, exactly `cfg_post` further accepted samples are stored, values above DEPTH being treated as DEPTH. The buffer then freezes and `done` rises. With `cfg_post` = 0, `done` rises in the cycle after the trigger.
- R7: A trigger that arrives while the recorder is idle, done or already capturing is ignored. A pulse on `arm` starts a new capture only from idle or done.
- R8: Once `done` is high, `rd_data` presents the oldest stored sample two cycles later. Each `rd_next` pulse moves the read address one entry forward in time, wrapping around the buffer. The new value appears two cycles after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | A new sample is present this cycle |
| smp_data | input | DATA_W | Sample value to record |
| sum_data | input | DATA_W | Signed sum channel for the threshold detector |
| inhibit | input | 1 | Sample taken without beam; do not store |
| turn_strobe | input | 1 | One-cycle pulse per machine turn |
| ext_trig | input | 1 | External trigger level (rising edge used) |
| sw_trig | input | 1 | Software trigger pulse |
| evt_trig | input | 1 | Timing-system event pulse |
| arm | input | 1 | Software arm pulse |
| cfg_src_en | input | 4 | Trigger source enables |
| cfg_thresh | input | DATA_W | Signed threshold for the sum channel |
| cfg_single | input | 1 | Event starts a turn countdown instead of firing |
| cfg_turns | input | TURN_W | Turns to wait in single-shot mode |
| cfg_post | input | AW+1 | Samples stored after the trigger |
| rd_next | input | 1 | Step the readout to the next-newer entry |
| armed | output | 1 | Waiting for a trigger, buffer wrapping |
| capturing | output | 1 | Trigger seen, post-trigger samples being stored |
| done | output | 1 | Buffer frozen and ready to read |
| rd_data | output | DATA_W | Buffer entry at the readout address |

## Verification
The bench targets the placement of the trigger sample relative to the post count. A design off by one there would read out a window shifted by one sample, or freeze one write early or late. It also exercises a post count of zero and one above the buffer depth, where a wrong clamp would run past the buffer. The threshold detector is held below the threshold for several samples while it is masked and then enabled. A level-sensitive detector would fire at once instead of waiting for a fresh crossing. Further cases cover the single-shot countdown with a turn strobe placed around the event, a retrigger during capture, and inhibited samples. A design that restarted on a retrigger, or stored inhibited samples, would return a readout that differs from the bench's own record of accepted samples.

// File: rtl/rec_pkg.sv
// Shared types for the transient recorder.
// Assumes: included first in compile order.
package rec_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_POST  = 2'd2,
        ST_DONE  = 2'd3
    } rec_state_e;

    localparam int SRC_EXT = 0;
    localparam int SRC_SW  = 1;
    localparam int SRC_EVT = 2;
    localparam int SRC_THR = 3;
    localparam int NUM_SRC = 4;
endpackage

// File: rtl/rec_trig_sel.sv
// Trigger selection: merges the four trigger sources under their enable mask.
// It edge-detects the external pin, detects the first sample of the sum channel
// below threshold, and runs the single-shot turn countdown.
// Assumes: all inputs are synchronous to clk; the countdown only runs while armed.
module rec_trig_sel
    import rec_pkg::*;
#(
    parameter int DATA_W = 14,
    parameter int TURN_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     armed,
    input  logic                     smp_valid,
    input  logic signed [DATA_W-1:0] sum_data,
    input  logic signed [DATA_W-1:0] cfg_thresh,
    input  logic [NUM_SRC-1:0]       cfg_src_en,
    input  logic                     cfg_single,
    input  logic [TURN_W-1:0]        cfg_turns,
    input  logic                     ext_trig,
    input  logic                     sw_trig,
    input  logic                     evt_trig,
    input  logic                     turn_strobe,
    output logic                     trig_fire
);
    logic              ext_q;
    logic              prev_below;
    logic              below;
    logic              thr_fire;
    logic              evt_en;
    logic              counting;
    logic [TURN_W-1:0] turns_left;
    logic              dly_fire;

    // Remembers the previous level of the external pin for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_q <= 1'b0;
        else        ext_q <= ext_trig;
    end

    assign below = (sum_data < cfg_thresh);

    // Tracks whether the last valid sum sample was below the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n)         prev_below <= 1'b0;
        else if (smp_valid) prev_below <= below;
    end

    assign thr_fire = smp_valid && below && !prev_below;
    assign evt_en   = evt_trig && cfg_src_en[SRC_EVT];

    // Counts turn strobes after a single-shot event, cleared whenever not armed.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed) begin
            counting   <= 1'b0;
            turns_left <= '0;
        end else if (counting) begin
            if (turn_strobe) begin
                if (turns_left == TURN_W'(1)) counting <= 1'b0;
                turns_left <= turns_left - 1'b1;
            end
        end else if (evt_en && cfg_single && (cfg_turns != '0)) begin
            counting   <= 1'b1;
            turns_left <= cfg_turns;
        end
    end

    assign dly_fire = (counting && turn_strobe && (turns_left == TURN_W'(1)))
                   || (!counting && evt_en && cfg_single && (cfg_turns == '0));

    // Combines all enabled sources into one trigger pulse.
    always_comb begin
        trig_fire = dly_fire;
        if (cfg_src_en[SRC_EXT] && ext_trig && !ext_q) trig_fire = 1'b1;
        if (cfg_src_en[SRC_SW]  && sw_trig)            trig_fire = 1'b1;
        if (evt_en && !cfg_single)                     trig_fire = 1'b1;
        if (cfg_src_en[SRC_THR] && thr_fire)           trig_fire = 1'b1;
    end

    // R4
    thr_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thr_fire |=> !thr_fire)
        else $error("threshold detector fired on two samples in a row");

    // R5
    count_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> !counting)
        else $error("turn countdown survived leaving the armed state");
endmodule

// File: rtl/rec_ctrl.sv
// Capture controller: arm, pre-trigger wrap, post-trigger count, freeze.
// Owns the write pointer. The sample accepted in the trigger cycle counts as
// pre-trigger; a post count above DEPTH is clamped to DEPTH.
// Assumes: trig_fire is a single-cycle pulse computed in the same cycle.
module rec_ctrl
    import rec_pkg::*;
#(
    parameter int DEPTH = 4096,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          trig_fire,
    input  logic          smp_valid,
    input  logic          inhibit,
    input  logic [AW:0]   cfg_post,
    output logic          wr_en,
    output logic [AW-1:0] wr_ptr,
    output logic          armed,
    output logic          capturing,
    output logic          done
);
    localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

    rec_state_e  state;
    logic [AW:0] remain;
    logic [AW:0] post_lim;
    logic        accept;

    assign post_lim = (cfg_post > DEPTH_V) ? DEPTH_V : cfg_post;
    assign accept   = smp_valid && !inhibit;
    assign wr_en    = accept && ((state == ST_ARMED) || (state == ST_POST));

    // Steps the capture state machine and the post-trigger counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            remain <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: if (arm) state <= ST_ARMED;
                ST_ARMED: begin
                    if (trig_fire) begin
                        remain <= post_lim;
                        state  <= (post_lim == '0) ? ST_DONE : ST_POST;
                    end
                end
                ST_POST: begin
                    if (accept) begin
                        remain <= remain - 1'b1;
                        if (remain == (AW+1)'(1)) state <= ST_DONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Advances the circular write pointer on every stored sample.
    always_ff @(posedge clk) begin
        if (!rst_n)     wr_ptr <= '0;
        else if (wr_en) wr_ptr <= wr_ptr + 1'b1;
    end

    assign armed     = (state == ST_ARMED);
    assign capturing = (state == ST_POST);
    assign done      = (state == ST_DONE);

    // R2
    inhibit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |=> $stable(wr_ptr))
        else $error("inhibited sample advanced the write pointer");

    // R6
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !arm |=> done && $stable(wr_ptr))
        else $error("frozen buffer changed or left done without arm");

    // R6
    done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capturing && !wr_en |=> !done)
        else $error("capture finished without a final stored sample");

    // R7
    idle_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) && !arm |=> (state == ST_IDLE))
        else $error("recorder left idle without an arm request");
endmodule

// File: rtl/rec_buffer.sv
// Sample storage: one write port and one registered read port.
// The read data register has no reset, as a block RAM output would.
// Assumes: read address and write address are independent.
module rec_buffer #(
    parameter int DATA_W = 14,
    parameter int DEPTH  = 4096,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Writes accepted samples and registers the addressed entry for readout.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
        rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/rec_reader.sv
// Readout address generator: jumps to the oldest entry when the buffer freezes,
// then steps one entry per rd_next, wrapping naturally over the power-of-two depth.
// Assumes: oldest (the write pointer) is stable while done is high.
module rec_reader #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done,
    input  logic [AW-1:0] oldest,
    input  logic          rd_next,
    output logic [AW-1:0] rd_addr
);
    logic frozen_q;

    // Delays done by one cycle to find the moment the buffer froze.
    always_ff @(posedge clk) begin
        if (!rst_n) frozen_q <= 1'b0;
        else        frozen_q <= done;
    end

    // Loads the oldest address on freeze, then steps on each read request.
    always_ff @(posedge clk) begin
        if (!rst_n)                              rd_addr <= '0;
        else if (done && !frozen_q)              rd_addr <= oldest;
        else if (done && frozen_q && rd_next)    rd_addr <= rd_addr + 1'b1;
    end

    // R8
    rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && frozen_q && rd_next |=> rd_addr == $past(rd_addr) + 1'b1)
        else $error("readout address did not step by one");

    // R8
    rd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !frozen_q |=> rd_addr == $past(oldest))
        else $error("readout did not start at the oldest entry");
endmodule

// File: rtl/transient_recorder.sv
// Top level of the triggered transient recorder. Wires trigger selection,
// capture control, sample storage and readout addressing together.
// Assumes: DEPTH is a power of two; all inputs synchronous to clk.
module transient_recorder
    import rec_pkg::*;
#(
    parameter int DATA_W = 14,
    parameter int DEPTH  = 4096,
    parameter int TURN_W = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_valid,
    input  logic [DATA_W-1:0]        smp_data,
    input  logic signed [DATA_W-1:0] sum_data,
    input  logic                     inhibit,
    input  logic                     turn_strobe,
    input  logic                     ext_trig,
    input  logic                     sw_trig,
    input  logic                     evt_trig,
    input  logic                     arm,
    input  logic [NUM_SRC-1:0]       cfg_src_en,
    input  logic signed [DATA_W-1:0] cfg_thresh,
    input  logic                     cfg_single,
    input  logic [TURN_W-1:0]        cfg_turns,
    input  logic [AW:0]              cfg_post,
    input  logic                     rd_next,
    output logic                     armed,
    output logic                     capturing,
    output logic                     done,
    output logic [DATA_W-1:0]        rd_data
);
    logic          trig_fire;
    logic          wr_en;
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_addr;

    rec_trig_sel #(.DATA_W(DATA_W), .TURN_W(TURN_W)) u_trig (
        .clk(clk), .rst_n(rst_n), .armed(armed), .smp_valid(smp_valid),
        .sum_data(sum_data), .cfg_thresh(cfg_thresh), .cfg_src_en(cfg_src_en),
        .cfg_single(cfg_single), .cfg_turns(cfg_turns), .ext_trig(ext_trig),
        .sw_trig(sw_trig), .evt_trig(evt_trig), .turn_strobe(turn_strobe),
        .trig_fire(trig_fire)
    );

    rec_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .arm(arm), .trig_fire(trig_fire),
        .smp_valid(smp_valid), .inhibit(inhibit), .cfg_post(cfg_post),
        .wr_en(wr_en), .wr_ptr(wr_ptr), .armed(armed),
        .capturing(capturing), .done(done)
    );

    rec_buffer #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_buf (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_ptr), .wr_data(smp_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    rec_reader #(.AW(AW)) u_rd (
        .clk(clk), .rst_n(rst_n), .done(done), .oldest(wr_ptr),
        .rd_next(rd_next), .rd_addr(rd_addr)
    );

    // R7
    one_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({armed, capturing, done}))
        else $error("more than one recorder state flag high");
endmodule

// File: tb/sim_transient_recorder.sv
// Bench for the transient recorder: table-driven captures, then directed cases.
module sim_transient_recorder;
    localparam int DW = 12;
    localparam int DEPTH = 16;
    localparam int AW = 4;
    localparam int TW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 0, inhibit = 0, turn_strobe = 0;
    logic ext_trig = 0, sw_trig = 0, evt_trig = 0, arm = 0, rd_next = 0;
    logic cfg_single = 0;
    logic [DW-1:0] smp_data = '0;
    logic signed [DW-1:0] sum_data = 12'sd100;
    logic signed [DW-1:0] cfg_thresh = '0;
    logic [3:0] cfg_src_en = '0;
    logic [TW-1:0] cfg_turns = '0;
    logic [AW:0] cfg_post = '0;
    logic armed, capturing, done;
    logic [DW-1:0] rd_data;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    int seq = 1;
    logic [DW-1:0] hist [256];
    int nhist;

    always #5 clk = ~clk;

    transient_recorder #(.DATA_W(DW), .DEPTH(DEPTH), .TURN_W(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .sum_data(sum_data), .inhibit(inhibit), .turn_strobe(turn_strobe),
        .ext_trig(ext_trig), .sw_trig(sw_trig), .evt_trig(evt_trig), .arm(arm),
        .cfg_src_en(cfg_src_en), .cfg_thresh(cfg_thresh), .cfg_single(cfg_single),
        .cfg_turns(cfg_turns), .cfg_post(cfg_post), .rd_next(rd_next),
        .armed(armed), .capturing(capturing), .done(done), .rd_data(rd_data)
    );

    // Table fields: [23:21] source (0 ext,1 sw,2 evt,3 thr,4 single-shot evt),
    // [20:16] post, [15:8] pre-trigger cycles, [7:4] turns, [3] inhibit, [2] retrigger
    localparam int NROW = 8;
    localparam logic [23:0] VEC [NROW] = '{
        {3'd0, 5'd5,  8'd20, 4'd0, 1'b0, 1'b0, 2'b0},
        {3'd1, 5'd16, 8'd18, 4'd0, 1'b0, 1'b0, 2'b0},
        {3'd2, 5'd8,  8'd30, 4'd0, 1'b1, 1'b0, 2'b0},
        {3'd3, 5'd3,  8'd25, 4'd0, 1'b0, 1'b0, 2'b0},
        {3'd4, 5'd6,  8'd20, 4'd3, 1'b0, 1'b0, 2'b0},
        {3'd1, 5'd10, 8'd40, 4'd0, 1'b1, 1'b1, 2'b0},
        {3'd1, 5'd0,  8'd22, 4'd0, 1'b0, 1'b0, 2'b0},
        {3'd0, 5'd20, 8'd19, 4'd0, 1'b0, 1'b0, 2'b0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_arm();
        @(negedge clk);
        smp_valid = 0; arm = 1;
        @(negedge clk);
        arm = 0;
    endtask

    task automatic read_out(input string req);
        @(negedge clk);
        @(negedge clk);
        for (int i = 0; i < DEPTH; i++) begin
            chk(rd_data == hist[nhist - DEPTH + i], req, rd_data, hist[nhist - DEPTH + i]);
            rd_next = 1;
            @(negedge clk);
            rd_next = 0;
            @(negedge clk);
        end
    endtask

    task automatic run_row(input int r);
        int src, post, npre, turns, plim, remain, cnt;
        bit inh, retrig, fire, pend, acc, early;
        int mstate;
        src = VEC[r][23:21]; post = VEC[r][20:16]; npre = VEC[r][15:8];
        turns = VEC[r][7:4]; inh = VEC[r][3]; retrig = VEC[r][2];
        plim = (post > DEPTH) ? DEPTH : post;
        cfg_post = AW'(0) + post[AW:0];
        cfg_turns = turns[TW-1:0];
        cfg_single = (src == 4);
        cfg_thresh = '0;
        case (src)
            0: cfg_src_en = 4'b0001;
            1: cfg_src_en = 4'b0010;
            3: cfg_src_en = 4'b1000;
            default: cfg_src_en = 4'b0100;
        endcase
        do_arm();
        nhist = 0; mstate = 1; pend = 0; cnt = 0; early = 0; remain = 0;
        for (int c = 0; c < 300 && mstate != 3; c++) begin
            @(negedge clk);
            if (done) early = 1;
            smp_valid = 1;
            smp_data = seq[DW-1:0];
            inhibit = inh && (c % 3 == 1);
            turn_strobe = (c % 4 == 3);
            ext_trig = (src == 0) && (c >= npre) && (c < npre + 3);
            sw_trig = (src == 1) && ((c == npre) || (retrig && c == npre + 3));
            evt_trig = (src == 2 || src == 4) && (c == npre);
            sum_data = ((src == 3) && (c == npre)) ? -12'sd3 : 12'sd100;
            fire = 0;
            if (src == 4) begin
                if (pend && turn_strobe) begin
                    cnt--;
                    if (cnt == 0) begin fire = 1; pend = 0; end
                end
                if (c == npre) begin
                    if (turns == 0) fire = 1;
                    else begin pend = 1; cnt = turns; end
                end
            end else begin
                fire = (src == 1) ? sw_trig : (c == npre);
            end
            acc = !inhibit;
            if (mstate == 1) begin
                if (acc) begin hist[nhist] = smp_data; nhist++; end
                if (fire) begin
                    remain = plim;
                    mstate = (plim == 0) ? 3 : 2;
                end
            end else if (mstate == 2) begin
                if (acc) begin
                    hist[nhist] = smp_data; nhist++;
                    remain--;
                    if (remain == 0) mstate = 3;
                end
            end
            seq++;
        end
        chk(!early, "R6 no early freeze", early, 0);
        @(negedge clk);
        smp_valid = 0; inhibit = 0; turn_strobe = 0; ext_trig = 0;
        sw_trig = 0; evt_trig = 0; sum_data = 12'sd100;
        chk(done == 1, "R6 done after post count", done, 1);
        case (src)
            0: read_out("R3 ext readout R8");
            1: read_out(retrig ? "R7 retrigger ignored R2" : "R3 sw readout R8");
            2: read_out("R2 inhibit readout R3");
            3: read_out("R4 threshold readout");
            default: read_out("R5 single-shot readout");
        endcase
    endtask

    task automatic feed(input logic signed [DW-1:0] s);
        @(negedge clk);
        smp_valid = 1; smp_data = seq[DW-1:0]; sum_data = s; seq++;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(!armed && !capturing && !done, "R1 reset state", {armed, capturing, done}, 0);

        // R7: trigger while idle is ignored
        cfg_src_en = 4'b1111; cfg_post = 5'd2;
        @(negedge clk); sw_trig = 1;
        @(negedge clk); sw_trig = 0;
        @(negedge clk);
        chk(!capturing && !done && !armed, "R7 idle trigger ignored", {armed, capturing, done}, 0);

        // R3: disabled source has no effect
        cfg_src_en = 4'b0010;
        do_arm();
        chk(armed == 1, "R7 arm from idle", armed, 1);
        ext_trig = 1;
        @(negedge clk); ext_trig = 0;
        @(negedge clk);
        chk(armed && !capturing, "R3 masked ext ignored", capturing, 0);

        // R4: detector fires only on a fresh crossing
        cfg_thresh = '0;
        for (int i = 0; i < 3; i++) feed(-12'sd3);
        @(negedge clk); cfg_src_en = 4'b1000; smp_valid = 0;
        for (int i = 0; i < 3; i++) feed(-12'sd3);
        @(negedge clk); smp_valid = 0;
        chk(armed && !capturing, "R4 held-low level does not fire", capturing, 0);
        feed(12'sd50);
        feed(-12'sd1);
        @(negedge clk); smp_valid = 0;
        chk(capturing == 1, "R4 fresh crossing fires", capturing, 1);
        feed(12'sd50);
        @(negedge clk); smp_valid = 0;
        chk(capturing && !done, "R6 one of two post samples", done, 0);
        feed(12'sd50);
        @(negedge clk); smp_valid = 0;
        chk(done == 1, "R6 done after two post samples", done, 1);

        // Table of capture scenarios
        for (int r = 0; r < NROW; r++) run_row(r);

        // R7: arm while capturing does not restart
        cfg_src_en = 4'b0010; cfg_post = 5'd4; cfg_single = 0;
        do_arm();
        @(negedge clk); sw_trig = 1;
        @(negedge clk); sw_trig = 0; arm = 1;
        @(negedge clk); arm = 0;
        chk(capturing == 1, "R7 arm during capture ignored", capturing, 1);

        // R1 reset clears capture
        rst_n = 0;
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk(!armed && !capturing && !done, "R1 reset from capture", {armed, capturing, done}, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule